// File: doc/BRIEF.md
# USB Bus Suspend and Remote-Wakeup Controller

This block handles the power-management side of a USB device controller. It watches a bus-activity strobe from the line decoder and, when software has enabled it, moves the device into suspend once the bus has been quiet for a fixed idle period, nominally 3 ms. It gives a one-cycle interrupt pulse when that happens. It also reports when reset signaling is present on the bus.

Software can leave suspend in two ways. It can read the common interrupt flag register, which the surrounding controller signals with a strobe. It can also start remote-wakeup resume signaling by setting the resume bit. Resume signaling is timed by software, normally for about 10 ms and always between 1 ms and 15 ms. A hardware guard drops the drive after a parameterised maximum if software forgets to clear the bit.

All control and status sit in one byte-wide register: enable at bit 0, suspend status at bit 1, resume at bit 2 and reset status at bit 3. The remaining bits read as zero.

Top module: `usb_susp_ctl`

## Requirements
- R1: With the enable bit (bit 0) at 1, `susp_stat` rises on the (IDLE_CYCLES+1)-th rising clock edge after the last edge at which `bus_act` was sampled high, provided no clear or bus reset comes in between.
- R2: With the enable bit at 0, suspend status never sets, however long the bus stays idle. If the bus is already past the idle limit when enable is written to 1, suspend sets on the next edge after the write edge.
- R3: A one-cycle `irq_rd` strobe clears suspend status on that edge and restarts the idle period from that edge.
- R4: A register write with bit 2 at 1 clears suspend status on the write edge and restarts the idle period.
- R5: `rst_stat` and register bit 3 follow `bus_rst` one clock later. While `bus_rst` is high, suspend status is clear and the idle period is held at its start.
- R6: `resume_drv` equals register bit 2. It rises on the edge that writes 1 to bit 2 and falls on the edge that writes 0 to it.
- R7: `susp_irq` is high for exactly one cycle, the first cycle in which `susp_stat` is 1. It is not repeated while suspend persists.
- R8: If bit 2 stays set, `resume_drv` stays high for exactly RESUME_MAX cycles and then falls, and bit 2 reads back as 0.
- R9: Writes to bits 1 and 3 and to bits 7:4 have no effect. Bits 7:4 always read 0.
- R10: After reset every register bit reads 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_act | input | 1 | One-cycle strobe for any bus activity |
| bus_rst | input | 1 | Level, high while reset signaling is detected |
| irq_rd | input | 1 | Strobe for a read of the common interrupt flag register |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| susp_stat | output | 1 | Suspend status |
| rst_stat | output | 1 | Bus reset status |
| resume_drv | output | 1 | Resume-signaling drive enable toward the transceiver |
| susp_irq | output | 1 | One-cycle pulse on entry into suspend |

## Verification
The bench builds the block with IDLE_CYCLES=20 and RESUME_MAX=40 in place of the millisecond-scale defaults. This makes the exact suspend-entry edge, the restart of the idle period after each clear path, and the cutoff edge of the resume guard all reachable within a few hundred cycles. With these short windows the bench can check the cycle before and the cycle of each transition, so an off-by-one error in either counter shows up at the ports.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
  localparam int EN_BIT   = 0;
  localparam int SUSP_BIT = 1;
  localparam int RSM_BIT  = 2;
  localparam int RST_BIT  = 3;

  function automatic logic idle_done(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

  function automatic logic guard_hit(input int unsigned cnt, input int unsigned lim);
    return cnt == lim - 1;
  endfunction

  function automatic logic [7:0] pack_status(input logic en, input logic susp,
                                             input logic rsm, input logic rst);
    logic [7:0] v;
    v = 8'h00;
    v[EN_BIT]   = en;
    v[SUSP_BIT] = susp;
    v[RSM_BIT]  = rsm;
    v[RST_BIT]  = rst;
    return v;
  endfunction
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 144000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign expired = usb_susp_pkg::idle_done(int'(cnt_q), IDLE_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (restart)    cnt_q <= '0;
    else if (!expired)   cnt_q <= cnt_q + 1'b1;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !restart) |=> expired); // R1
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired); // R3
endmodule

// File: rtl/usb_resume_guard.sv
module usb_resume_guard #(
  parameter int unsigned RESUME_MAX = 720000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic drive,
  output logic timeout
);
  localparam int CW = $clog2(RESUME_MAX + 1);

  logic          bit_q;
  logic [CW-1:0] cnt_q;

  assign drive   = bit_q;
  assign timeout = bit_q && usb_susp_pkg::guard_hit(int'(cnt_q), RESUME_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else if (timeout) begin
      bit_q <= 1'b0;
    end else if (wr_en) begin
      bit_q <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!bit_q) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_GUARD_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !drive); // R8
  AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_val && !timeout) |=> drive); // R6
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_val) |=> !drive); // R6
endmodule

// File: rtl/usb_susp_flag.sv
module usb_susp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic expired,
  input  logic clear,
  input  logic bus_rst,
  output logic susp,
  output logic irq,
  output logic set_evt
);
  logic susp_q;
  logic irq_q;

  assign set_evt = enable && expired && !susp_q && !clear && !bus_rst;
  assign susp    = susp_q;
  assign irq     = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= set_evt;
      if (clear || bus_rst) susp_q <= 1'b0;
      else if (set_evt)     susp_q <= 1'b1;
    end
  end

  AST_ENTRY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> $past(enable)); // R2
  AST_IRQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R7
  AST_IRQ_WITH_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> susp_q); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !susp_q); // R3
  AST_BUSRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (!susp_q && !irq_q)); // R5
endmodule

// File: rtl/usb_susp_ctl.sv
module usb_susp_ctl #(
  parameter int unsigned IDLE_CYCLES = 144000,
  parameter int unsigned RESUME_MAX  = 720000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_act,
  input  logic       bus_rst,
  input  logic       irq_rd,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       susp_stat,
  output logic       rst_stat,
  output logic       resume_drv,
  output logic       susp_irq
);
  import usb_susp_pkg::*;

  logic en_q;
  logic rst_q;
  logic sw_resume;
  logic susp_clr;
  logic idle_restart;
  logic idle_expired;
  logic susp_set;
  logic guard_timeout;

  assign sw_resume    = reg_we && reg_wdata[RSM_BIT];
  assign susp_clr     = irq_rd || sw_resume;
  assign idle_restart = bus_act || bus_rst || susp_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= bus_rst;
      if (reg_we) en_q <= reg_wdata[EN_BIT];
    end
  end

  usb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (idle_restart),
    .expired (idle_expired)
  );

  usb_susp_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (en_q),
    .expired (idle_expired),
    .clear   (susp_clr),
    .bus_rst (bus_rst),
    .susp    (susp_stat),
    .irq     (susp_irq),
    .set_evt (susp_set)
  );

  usb_resume_guard #(.RESUME_MAX(RESUME_MAX)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .wr_val  (reg_wdata[RSM_BIT]),
    .drive   (resume_drv),
    .timeout (guard_timeout)
  );

  assign rst_stat  = rst_q;
  assign reg_rdata = pack_status(en_q, susp_stat, resume_drv, rst_q);

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    susp_set |=> (susp_stat && susp_irq)); // R1
  AST_RESUME_CLEARS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    sw_resume |=> !susp_stat); // R4
  AST_RST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> rst_stat); // R5
  AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !susp_stat) |=> !susp_stat); // R2
endmodule

// File: tb/usb_susp_ctl_bench.sv
module usb_susp_ctl_bench;
  localparam int unsigned IDLE = 20;
  localparam int unsigned RMAX = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_act = 1'b0;
  logic       bus_rst = 1'b0;
  logic       irq_rd = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       susp_stat, rst_stat, resume_drv, susp_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_susp_ctl #(.IDLE_CYCLES(IDLE), .RESUME_MAX(RMAX)) u_usb_susp_ctl (
    .clk(clk), .rst_n(rst_n), .bus_act(bus_act), .bus_rst(bus_rst),
    .irq_rd(irq_rd), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .susp_stat(susp_stat), .rst_stat(rst_stat),
    .resume_drv(resume_drv), .susp_irq(susp_irq)
  );

  // expected register image: en bit0, suspend bit1, resume bit2, reset bit3
  function automatic logic [7:0] img(input bit en, input bit s, input bit r, input bit b);
    return {4'h0, b, r, s, en};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance one edge and sample just after it
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // drive inputs for exactly one sampled edge
  task automatic wr(input logic [7:0] d, input bit act);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = d; bus_act = act;
    tick(1);
    @(negedge clk);
    reg_we = 1'b0; bus_act = 1'b0;
  endtask

  task automatic t_reset;
    chk(reg_rdata == 8'h00, "R10 rdata", reg_rdata, 0);
    chk({susp_stat, rst_stat, resume_drv, susp_irq} == 4'b0, "R10 outputs",
        {susp_stat, rst_stat, resume_drv, susp_irq}, 0);
  endtask

  task automatic t_idle_entry;
    wr(8'h01, 1'b1);           // activity sampled on the write edge
    tick(IDLE);
    chk(susp_stat == 1'b0, "R1 before limit", susp_stat, 0);
    tick(1);
    chk(susp_stat == 1'b1, "R1 entry edge", susp_stat, 1);
    chk(susp_irq == 1'b1, "R7 pulse", susp_irq, 1);
    chk(reg_rdata == img(1, 1, 0, 0), "R1 status bit", reg_rdata, img(1, 1, 0, 0));
    tick(1);
    chk(susp_irq == 1'b0 && susp_stat, "R7 single", susp_irq, 0);
    tick(5);
    chk(susp_irq == 1'b0, "R7 no repeat", susp_irq, 0);
  endtask

  task automatic t_clear_read;
    @(negedge clk); irq_rd = 1'b1;
    tick(1);
    @(negedge clk); irq_rd = 1'b0;
    chk(susp_stat == 1'b0, "R3 cleared", susp_stat, 0);
    tick(IDLE);
    chk(susp_stat == 1'b0, "R3 restart", susp_stat, 0);
    tick(1);
    chk(susp_stat == 1'b1, "R3 re-entry", susp_stat, 1);
  endtask

  task automatic t_resume_clear;
    wr(8'h05, 1'b0);
    chk(susp_stat == 1'b0, "R4 resume clears", susp_stat, 0);
    chk(resume_drv == 1'b1, "R6 drive on", resume_drv, 1);
    chk(reg_rdata == img(1, 0, 1, 0), "R6 readback", reg_rdata, img(1, 0, 1, 0));
    wr(8'h01, 1'b1);
    chk(resume_drv == 1'b0, "R6 drive off", resume_drv, 0);
  endtask

  task automatic t_disabled;
    wr(8'h00, 1'b1);
    tick(3 * IDLE);
    chk(susp_stat == 1'b0, "R2 disabled", susp_stat, 0);
    wr(8'h01, 1'b0);
    chk(susp_stat == 1'b0, "R2 write edge", susp_stat, 0);
    tick(1);
    chk(susp_stat == 1'b1, "R2 late enable", susp_stat, 1);
  endtask

  task automatic t_bus_reset;
    chk(susp_stat == 1'b1, "R5 pre suspended", susp_stat, 1);
    @(negedge clk); bus_rst = 1'b1;
    tick(1);
    chk(rst_stat == 1'b1 && susp_stat == 1'b0, "R5 reset seen",
        {rst_stat, susp_stat}, 2'b10);
    chk(reg_rdata == img(1, 0, 0, 1), "R5 bit3", reg_rdata, img(1, 0, 0, 1));
    tick(IDLE + 5);
    chk(susp_stat == 1'b0, "R5 held", susp_stat, 0);
    @(negedge clk); bus_rst = 1'b0;
    tick(1);
    chk(rst_stat == 1'b0, "R5 released", rst_stat, 0);
    tick(IDLE - 1);
    chk(susp_stat == 1'b0, "R5 timer restarted", susp_stat, 0);
    tick(1);
    chk(susp_stat == 1'b1, "R5 re-entry", susp_stat, 1);
  endtask

  task automatic t_guard;
    wr(8'h04, 1'b1);           // write edge W
    chk(resume_drv == 1'b1, "R8 start", resume_drv, 1);
    tick(RMAX - 1);
    chk(resume_drv == 1'b1, "R8 last high", resume_drv, 1);
    tick(1);
    chk(resume_drv == 1'b0, "R8 cut", resume_drv, 0);
    chk(reg_rdata == 8'h00, "R8 readback", reg_rdata, 0);
  endtask

  task automatic t_ro_write;
    wr(8'hFE, 1'b1);
    chk(reg_rdata == img(0, 0, 1, 0), "R9 ro ignored", reg_rdata, img(0, 0, 1, 0));
    wr(8'h0B, 1'b1);
    chk(reg_rdata == img(1, 0, 0, 0), "R9 ro bits", reg_rdata, img(1, 0, 0, 0));
    chk(rst_stat == 1'b0 && susp_stat == 1'b0, "R9 outputs untouched",
        {rst_stat, susp_stat}, 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    tick(1);
    t_reset();
    t_idle_entry();
    t_clear_read();
    t_resume_clear();
    t_disabled();
    t_bus_reset();
    t_guard();
    t_ro_write();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule